// File: doc/BRIEF.md
# Serial link symbol pacer

This block sits in front of the symbol emitter of a serial link transmitter. It takes 8-bit tokens from upstream over a valid/ready handshake, cuts each token into symbols and raises a one-cycle symbol strobe for each, with the symbol bits beside it. All spacing is counted in cycles of the one clock it runs on, the switch clock.

Two spacing fields are written through a small register port. The symbol field sets the gap between successive symbol strobes: field value plus one cycle, never less than two. The token field sets the gap from the last symbol of a token to the first symbol of the next: field value plus two cycles. A token boundary waits for whichever of the two gaps is longer. After reset the link runs slowly enough to boot safely. Both gaps are 400 cycles and the narrow two-pair lane mode is selected.

A mode bit picks between two lane widths. The two-pair mode sends four 2-bit symbols per token. The five-wire mode sends two 4-bit symbols per token.

Top module: `link_pacer`

## Requirements
- R1: After reset the token field reads as 398 and the symbol field as 399, so both gaps are 400 cycles, the mode is two-pair (wide_mode low), tok_ready is high and sym_strobe is low. The first token accepted after reset strobes its first symbol in the cycle right after acceptance.
- R2: Inside one token, successive sym_strobe pulses are exactly G cycles apart, where G = symbol field + 1 (cfg_addr 1, cfg_wdata[10:0]).
- R3: When symbol field + 1 is below 2 (field 0), the symbol gap used is 2 cycles.
- R4: The first strobe of a token comes at the later of two cycles: the cycle after its acceptance, and the last strobe of the previous token plus max(token field + 2, symbol gap) cycles. The token field is at cfg_addr 0, cfg_wdata[10:0].
- R5: In two-pair mode a token gives 4 strobes. Each carries 2 bits in sym_data[1:0], least significant pair first, with sym_data[3:2] zero. sym_last is high on the fourth.
- R6: In five-wire mode a token gives 2 strobes carrying 4 bits in sym_data[3:0], low nibble first. sym_last is high on the second.
- R7: tok_ready is high exactly when no token is held. A token is taken on a clock edge where tok_valid and tok_ready are both high. sym_strobe never rises while tok_ready is high.
- R8: A spacing write that lands while a gap is being counted leaves that gap unchanged. The new value applies from the next strobe on.
- R9: Writing cfg_addr 2 sets the mode from cfg_wdata[0] (1 = five-wire), and wide_mode shows the new value in the next cycle. The mode is captured per token at acceptance, so a token in flight keeps its lane width. Writes to cfg_addr 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 token field, 1 symbol field, 2 mode |
| cfg_wdata | input | 16 | Register write data |
| tok_valid | input | 1 | Upstream token present |
| tok_data | input | 8 | Upstream token value |
| tok_ready | output | 1 | Pacer can take a token |
| sym_strobe | output | 1 | One-cycle pulse per emitted symbol |
| sym_data | output | 4 | Symbol bits, valid with sym_strobe |
| sym_last | output | 1 | Marks the final symbol of a token |
| wide_mode | output | 1 | Current lane mode, 1 = five-wire |

## Verification
A wrong gap countdown shows on the next strobe as a pulse that arrives early or late, so the bench timestamps every strobe and compares it with a cycle it derives itself from the register values in force at the previous strobe. A bad shift register or symbol index shows within one token, as wrong symbol bits or a misplaced last marker. A mode captured at the wrong moment shows on the first token after a mode write. Random spacings, modes and idle gaps are mixed with directed cases: the clamped minimum gap, the largest token gap, writes that land during a gap, and a mode flip while a token is in flight.

// File: rtl/pace_pkg.sv
// Shared definitions for the symbol pacer: register addresses and lane mode.
// Assumes a 2-bit register address space.
package pace_pkg;
    localparam logic [1:0] ADDR_TOK_GAP = 2'd0;
    localparam logic [1:0] ADDR_SYM_GAP = 2'd1;
    localparam logic [1:0] ADDR_MODE    = 2'd2;

    typedef enum logic {
        LANE_PAIR = 1'b0,
        LANE_WIDE = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/pace_regs.sv
// Spacing and mode registers of the pacer.
// Holds the raw token and symbol spacing fields and the lane mode bit.
// Assumes single-cycle writes. Unknown addresses are ignored.
module pace_regs
    import pace_pkg::*;
#(
    parameter int SPC_W   = 11,
    parameter int DATA_W  = 16,
    parameter int TOK_RST = 398,
    parameter int SYM_RST = 399
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SPC_W-1:0]  tok_fld,
    output logic [SPC_W-1:0]  sym_fld,
    output lane_mode_e        mode
);
    // Register update: boot-safe defaults on reset, then decoded writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_fld <= SPC_W'(TOK_RST);
            sym_fld <= SPC_W'(SYM_RST);
            mode    <= LANE_PAIR;
        end else if (we) begin
            case (addr)
                ADDR_TOK_GAP: tok_fld <= wdata[SPC_W-1:0];
                ADDR_SYM_GAP: sym_fld <= wdata[SPC_W-1:0];
                ADDR_MODE:    mode    <= lane_mode_e'(wdata[0]);
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/pace_gap.sv
// Gap timer of the pacer.
// Converts the raw fields into cycle counts (token +2, symbol +1, clamped to a
// floor) and loads a down-counter at each strobe. The next strobe may go once
// the counter reaches zero. The fields are sampled only at the strobe, so a
// write during a gap applies from the next boundary.
// Assumes the strobe is only asserted while gap_open is high.
module pace_gap #(
    parameter int SPC_W       = 11,
    parameter int CNT_W       = 13,
    parameter int MIN_SYM_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPC_W-1:0] tok_fld,
    input  logic [SPC_W-1:0] sym_fld,
    input  logic             fire,
    input  logic             end_of_tok,
    output logic             gap_open
);
    localparam logic [CNT_W-1:0] TOK_OFS = CNT_W'(2);
    localparam logic [CNT_W-1:0] SYM_OFS = CNT_W'(1);
    localparam logic [CNT_W-1:0] SYM_MIN = CNT_W'(MIN_SYM_GAP);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] sym_raw, sym_gap, tok_gap, load_gap, remain;

    // Decode both fields into cycle counts and choose the gap for this boundary.
    always_comb begin
        sym_raw  = CNT_W'(sym_fld) + SYM_OFS;
        sym_gap  = (sym_raw < SYM_MIN) ? SYM_MIN : sym_raw;
        tok_gap  = CNT_W'(tok_fld) + TOK_OFS;
        load_gap = sym_gap;
        if (end_of_tok && (tok_gap > sym_gap)) begin
            load_gap = tok_gap;
        end
    end

    // Countdown: load at each strobe, decrement to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (fire) begin
            remain <= load_gap - ONE;
        end else if (remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign gap_open = (remain == '0);
endmodule

// File: rtl/pace_serial.sv
// Token holder and symbol slicer of the pacer.
// Takes one token at a time, captures the lane mode with it, and emits its
// symbols least significant first, one per strobe, when the gap timer opens.
// Assumes TOK_W is a multiple of 4: a narrow symbol is TOK_W/4 bits and a wide
// symbol is TOK_W/2 bits.
module pace_serial
    import pace_pkg::*;
#(
    parameter int TOK_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_valid,
    input  logic [TOK_W-1:0]   tok_data,
    input  lane_mode_e         mode_cfg,
    input  logic               gap_open,
    output logic               tok_ready,
    output logic               sym_strobe,
    output logic [TOK_W/2-1:0] sym_data,
    output logic               sym_last
);
    localparam int NARROW_W = TOK_W / 4;
    localparam int WIDE_W   = TOK_W / 2;
    localparam int PAIR_N   = TOK_W / NARROW_W;
    localparam int WIDE_N   = TOK_W / WIDE_W;
    localparam int IDX_W    = $clog2(PAIR_N);
    localparam logic [IDX_W-1:0] PAIR_LAST = IDX_W'(PAIR_N - 1);
    localparam logic [IDX_W-1:0] WIDE_LAST = IDX_W'(WIDE_N - 1);

    logic             busy;
    logic [TOK_W-1:0] shreg;
    logic [IDX_W-1:0] idx;
    lane_mode_e       lane;
    logic             at_last;

    assign tok_ready  = !busy;
    assign at_last    = (idx == ((lane == LANE_WIDE) ? WIDE_LAST : PAIR_LAST));
    assign sym_strobe = busy && gap_open;
    assign sym_last   = sym_strobe && at_last;

    // Symbol bits: each output bit is the token bit in wide mode; in narrow mode
    // only the low lanes carry data.
    for (genvar g = 0; g < WIDE_W; g++) begin : g_lane
        if (g < NARROW_W) begin : g_shared
            assign sym_data[g] = shreg[g];
        end else begin : g_wide_only
            assign sym_data[g] = (lane == LANE_WIDE) ? shreg[g] : 1'b0;
        end
    end

    // Token capture on handshake, shift and index advance on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '0;
            idx   <= '0;
            lane  <= LANE_PAIR;
        end else if (!busy) begin
            if (tok_valid) begin
                busy  <= 1'b1;
                shreg <= tok_data;
                idx   <= '0;
                lane  <= mode_cfg;
            end
        end else if (sym_strobe) begin
            if (at_last) begin
                busy <= 1'b0;
            end else begin
                idx   <= idx + IDX_W'(1);
                shreg <= (lane == LANE_WIDE) ? (shreg >> WIDE_W) : (shreg >> NARROW_W);
            end
        end
    end
endmodule

// File: rtl/link_pacer.sv
// Serial link symbol pacer, top level.
// Joins the register block, the gap timer and the token slicer. Everything
// runs on the single switch clock with a synchronous active-low reset.
module link_pacer
    import pace_pkg::*;
#(
    parameter int SPC_W       = 11,
    parameter int DATA_W      = 16,
    parameter int TOK_W       = 8,
    parameter int TOK_RST     = 398,
    parameter int SYM_RST     = 399,
    parameter int MIN_SYM_GAP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               tok_valid,
    input  logic [TOK_W-1:0]   tok_data,
    output logic               tok_ready,
    output logic               sym_strobe,
    output logic [TOK_W/2-1:0] sym_data,
    output logic               sym_last,
    output logic               wide_mode
);
    localparam int CNT_W = SPC_W + 2;

    logic [SPC_W-1:0] tok_fld, sym_fld;
    lane_mode_e       mode;
    logic             gap_open;

    assign wide_mode = (mode == LANE_WIDE);

    pace_regs #(
        .SPC_W(SPC_W), .DATA_W(DATA_W), .TOK_RST(TOK_RST), .SYM_RST(SYM_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .tok_fld(tok_fld), .sym_fld(sym_fld), .mode(mode)
    );

    pace_gap #(
        .SPC_W(SPC_W), .CNT_W(CNT_W), .MIN_SYM_GAP(MIN_SYM_GAP)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .tok_fld(tok_fld), .sym_fld(sym_fld),
        .fire(sym_strobe), .end_of_tok(sym_last), .gap_open(gap_open)
    );

    pace_serial #(
        .TOK_W(TOK_W)
    ) u_serial (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_data(tok_data),
        .mode_cfg(mode), .gap_open(gap_open), .tok_ready(tok_ready),
        .sym_strobe(sym_strobe), .sym_data(sym_data), .sym_last(sym_last)
    );
endmodule

// File: rtl/link_pacer_chk.sv
// Port-level checker for the pacer, attached by bind.
// Tracks the cycles since the last strobe, the symbols emitted in the current
// token and the mode seen at each handshake.
module link_pacer_chk #(
    parameter int SPC_W  = 11,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              tok_valid,
    input logic              tok_ready,
    input logic              sym_strobe,
    input logic              sym_last,
    input logic              wide_mode
);
    localparam int SW = SPC_W + 3;
    localparam logic [SW-1:0] SAT = {SW{1'b1}};

    logic [SW-1:0] since;
    logic          seen;
    logic [2:0]    emitted;
    logic          tok_wide;
    logic          started;

    // Observation state: gap since the last strobe, symbols per token, mode at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since    <= '0;
            seen     <= 1'b0;
            emitted  <= '0;
            tok_wide <= 1'b0;
            started  <= 1'b0;
        end else begin
            started <= 1'b1;
            if (sym_strobe) begin
                since   <= SW'(1);
                seen    <= 1'b1;
                emitted <= sym_last ? 3'd0 : emitted + 3'd1;
            end else if (since != SAT) begin
                since <= since + SW'(1);
            end
            if (tok_valid && tok_ready) begin
                tok_wide <= wide_mode;
            end
        end
    end

    // R1: first cycle out of reset is idle, ready and in two-pair mode.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!sym_strobe && tok_ready && !wide_mode));

    // R3: strobes are never closer than two cycles.
    a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_strobe && seen) |-> (since >= SW'(2)));

    // R7: no strobe while the pacer offers to take a token.
    a_r7_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> !tok_ready);

    // R7: a completed handshake makes the pacer busy.
    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready) |=> !tok_ready);

    // R5 and R6: the last marker falls on the 4th (two-pair) or 2nd (five-wire) symbol.
    a_r5_r6_symbol_count: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_strobe && sym_last) |-> (emitted == (tok_wide ? 3'd1 : 3'd3)));

    // R9: a mode write shows on wide_mode in the next cycle.
    a_r9_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd2) |=> (wide_mode == $past(cfg_wdata[0])));
endmodule

bind link_pacer link_pacer_chk #(.SPC_W(SPC_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .sym_strobe(sym_strobe), .sym_last(sym_last), .wide_mode(wide_mode)
);

// File: tb/sim_link_pacer.sv
// Bench for the symbol pacer: directed corners plus seeded random traffic.
// Every strobe is timestamped and compared with a cycle computed from a
// bench-side model of the registers.
module sim_link_pacer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tok_valid = 1'b0;
    logic [7:0]  tok_data = '0;
    logic        tok_ready, sym_strobe, sym_last, wide_mode;
    logic [3:0]  sym_data;

    always #4 clk = ~clk;

    link_pacer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tok_valid(tok_valid), .tok_data(tok_data),
        .tok_ready(tok_ready), .sym_strobe(sym_strobe), .sym_data(sym_data),
        .sym_last(sym_last), .wide_mode(wide_mode)
    );

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_tok = 398;
    int m_sym = 399;
    bit m_wide = 1'b0;

    logic [3:0] q_sym[$];
    bit         q_last[$];
    bit         q_first[$];
    bit         q_wide[$];
    int         q_acc[$];
    int         prev_cyc = 0;
    bit         have_prev = 1'b0;
    int         gap_next = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int f_sym_gap(int fld);
        return max2(fld + 1, 2);
    endfunction

    function automatic int f_tok_gap(int fld);
        return fld + 2;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Register write: drive after a falling edge, update the model after the rising edge.
    task automatic wr(logic [1:0] a, int v);
        cfg_we = 1'b1;
        cfg_addr = a;
        cfg_wdata = 16'(v);
        @(posedge clk);
        #1;
        case (a)
            2'd0: m_tok = v & 32'h7FF;
            2'd1: m_sym = v & 32'h7FF;
            2'd2: m_wide = v[0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Offer a token, wait for the handshake and queue its expected symbols.
    task automatic send(logic [7:0] d);
        tok_valid = 1'b1;
        tok_data = d;
        while (!tok_ready) @(negedge clk);
        q_acc.push_back(cyc);
        if (m_wide) begin
            for (int k = 0; k < 2; k++) begin
                q_sym.push_back(d[k*4 +: 4]);
                q_last.push_back(k == 1);
                q_first.push_back(k == 0);
                q_wide.push_back(1'b1);
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                q_sym.push_back({2'b00, d[k*2 +: 2]});
                q_last.push_back(k == 3);
                q_first.push_back(k == 0);
                q_wide.push_back(1'b0);
            end
        end
        @(negedge clk);
        tok_valid = 1'b0;
        chk(tok_ready == 1'b0, "R7 ready after accept", int'(tok_ready), 0);
    endtask

    // Strobe monitor: timing (R2, R3, R4, R8), symbol bits and last marker (R5, R6).
    always @(negedge clk) begin
        if (rst_n && sym_strobe) begin
            if (q_sym.size() == 0) begin
                chk(1'b0, "R7 strobe with no token", 1, 0);
            end else begin
                logic [3:0] d;
                bit l, f, w;
                int acc, exp_c;
                d = q_sym.pop_front();
                l = q_last.pop_front();
                f = q_first.pop_front();
                w = q_wide.pop_front();
                if (f) begin
                    acc = q_acc.pop_front();
                    exp_c = max2(have_prev ? prev_cyc + gap_next : 0, acc + 1);
                    chk(cyc == exp_c, "R4 token boundary timing", cyc, exp_c);
                end else begin
                    exp_c = prev_cyc + gap_next;
                    chk(cyc == exp_c, "R2 symbol timing", cyc, exp_c);
                end
                chk(sym_data == d, w ? "R6 wide symbol bits" : "R5 pair symbol bits",
                    int'(sym_data), int'(d));
                chk(sym_last == l, w ? "R6 last marker" : "R5 last marker",
                    int'(sym_last), int'(l));
                gap_next = l ? max2(f_tok_gap(m_tok), f_sym_gap(m_sym)) : f_sym_gap(m_sym);
                prev_cyc = cyc;
                have_prev = 1'b1;
            end
        end
    end

    task automatic drain();
        while (q_sym.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state out of reset
        chk(tok_ready == 1'b1, "R1 ready after reset", int'(tok_ready), 1);
        chk(sym_strobe == 1'b0, "R1 no strobe after reset", int'(sym_strobe), 0);
        chk(wide_mode == 1'b0, "R1 two-pair after reset", int'(wide_mode), 0);

        // R1: boot spacing of 400 cycles for symbols and tokens
        send(8'hB4);
        send(8'h3C);
        drain();

        // R3: symbol field 0 clamps to a 2-cycle gap, token gap 2
        wr(2'd0, 0);
        wr(2'd1, 0);
        send(8'h1E);
        send(8'hE1);
        drain();

        // R8: spacing writes that land while a gap is counted
        wr(2'd1, 5);
        send(8'h5A);
        wr(2'd1, 20);
        wr(2'd0, 30);
        send(8'hA5);
        drain();

        // R9: mode write visible on wide_mode, R6 wide symbols
        wr(2'd2, 1);
        chk(wide_mode == 1'b1, "R9 wide_mode set", int'(wide_mode), 1);
        send(8'hC3);
        send(8'h96);
        // R9: mode flip while a token is in flight keeps its lane width
        send(8'h71);
        wr(2'd2, 0);
        chk(wide_mode == 1'b0, "R9 wide_mode cleared", int'(wide_mode), 0);
        send(8'h8E);
        // R9: writes to address 3 leave the mode alone
        wr(2'd3, 16'hFFFF);
        chk(wide_mode == 1'b0, "R9 address 3 ignored", int'(wide_mode), 0);
        drain();

        // R4: largest token gap, short symbol gap
        wr(2'd0, 16'h07FF);
        wr(2'd1, 2);
        send(8'h0F);
        send(8'hF0);
        drain();

        // Random spacings, modes, data and idle time
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 3) == 0) wr(2'd1, int'($urandom_range(0, 15)));
            if ($urandom_range(0, 3) == 0) wr(2'd0, int'($urandom_range(0, 40)));
            if ($urandom_range(0, 4) == 0) wr(2'd2, int'($urandom_range(0, 1)));
            send(8'($urandom_range(0, 255)));
            repeat ($urandom_range(0, 30)) @(negedge clk);
        end
        drain();
        chk(q_acc.size() == 0, "R7 every accepted token emitted", q_acc.size(), 0);
        finish_run();
    end
endmodule